// File: doc/BRIEF.md
# Smart Panel Command Sequencer

This block interprets a stream of 16-bit command words for an LCD panel that keeps its own frame memory and takes commands over a small parallel bus. Words arrive on a valid/ready input, which stands in for a command buffer fed by DMA. Each word is decoded. Bus opcodes become one request on a request/acknowledge port to a separate bus timing engine: a status read, a frame-memory read, a command-byte write, a data-byte write, or a frame write. Control opcodes do not touch the bus. One does nothing, one raises a sticky command interrupt, and one parks the sequencer until the next vertical sync pulse.

After a read the sequencer captures the panel byte. It then holds until software sets a continue flag, so that software can inspect the result before the list goes on. A list normally ends with an interrupt command and then a wait-for-vsync command, padded with no-ops to an even word count. A stop control releases the sequencer from either wait state and blocks any further fetching. A global enable input also gates fetching.

Top module: `lcdcmd_seq`

## Requirements
- R1: A word is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is high only while the sequencer is idle, `en` is 1 and the stop flag is clear. Word bits [11:9] are the opcode, bit [8] is the A0 value and bits [7:0] are the byte. Bits [15:12] are ignored.
- R2: Opcode 0 issues a read request: `bus_op`=0, `bus_a0` equal to word bit 8 (0 for the status register, 1 for frame memory), and `bus_wdata` equal to word bits [7:0].
- R3: Opcode 1 issues a write request: `bus_op`=1, with `bus_a0` and `bus_wdata` taken from the word (A0=0 for a command byte, A0=1 for a data byte).
- R4: Opcode 2 with A0=1 issues a frame-write request with `bus_op`=2. Opcode 2 with A0=0 behaves as a no-op.
- R5: `bus_req` rises in the cycle after the word is taken. It stays high with stable `bus_op`, `bus_a0` and `bus_wdata` until a cycle with `bus_ack` high, and is low in the next cycle.
- R6: On the acknowledge of a read, the panel status register (address 1) captures `bus_rdata` in bits [7:0] and the request's A0 in bit 8, and sets bit 9 (status OK). Bit 9 can also be written by software.
- R7: After a read the sequencer holds `cmd_ready` low until the continue flag (address 1, bit 10, set by writing 1) is seen. It then clears the flag and becomes ready one cycle later. If the flag is already set when the read is acknowledged, the sequencer is ready in the next cycle and the flag is cleared.
- R8: Opcode 3 holds `cmd_ready` low until a cycle with `vsync` high. The sequencer is ready in the following cycle.
- R9: Opcodes 4, 6 and 7 produce no bus request and no interrupt, and the sequencer is ready again in the next cycle.
- R10: Opcode 5 sets the interrupt bit (address 2, bit 0, also driven on `irq`) in the next cycle. The bit stays set until software writes 1 to it. Writing 0 has no effect.
- R11: Writing 1 to address 0 bit 0 sets the stop flag. The stop flag ends a wait for vsync or for continue, and keeps `cmd_ready` low until software writes 0. Reading address 0 returns the flag in bit 0.
- R12: After reset the sequencer is idle, `bus_req` and `irq` are low, and all register fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global fetch enable |
| cmd_valid | input | 1 | Command word valid |
| cmd_word | input | 16 | Command word |
| cmd_ready | output | 1 | Sequencer ready to take a word |
| vsync | input | 1 | Vertical sync pulse from the panel side |
| bus_req | output | 1 | Panel bus request |
| bus_op | output | 2 | Request kind: 0 read, 1 write, 2 frame write |
| bus_a0 | output | 1 | A0 line value for the request |
| bus_wdata | output | 8 | Byte for the request |
| bus_ack | input | 1 | Timing engine finished the request |
| bus_rdata | input | 8 | Byte returned by a read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 stop, 1 panel status, 2 interrupt) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Sticky command interrupt |

## Verification
A word taken at edge N shows its effect one cycle later. The bus request is visible after edge N. A no-op or an interrupt word makes `cmd_ready` or `irq` visible after edge N. A wait state is exited one edge after the releasing `vsync`, continue write or stop write lands in its register. The bench drives inputs at falling edges, so each result is sampled at the first falling edge after the rising edge that produces it. Each stall is checked at two points: the sequencer must still be blocked at the falling edge right after the releasing input is registered, and must be ready at the falling edge after that. The register fields are read back through the combinational read port half a cycle after the capturing edge.

// File: rtl/lcdcmd_pkg.sv
package lcdcmd_pkg;

    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int OPC_W     = 3;
    localparam int A0_POS    = 8;
    localparam int OPC_LSB   = 9;
    localparam int BOP_W     = 2;
    localparam int PST_OK    = 9;
    localparam int PST_CONT  = 10;
    localparam int ADDR_STOP = 0;
    localparam int ADDR_PST  = 1;
    localparam int ADDR_INT  = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_READ  = 3'd0,
        OPC_WRITE = 3'd1,
        OPC_FRAME = 3'd2,
        OPC_VSYNC = 3'd3,
        OPC_NOP   = 3'd4,
        OPC_IRQ   = 3'd5,
        OPC_RSV6  = 3'd6,
        OPC_RSV7  = 3'd7
    } opc_e;

    typedef enum logic [BOP_W-1:0] {
        BOP_RD    = 2'd0,
        BOP_WR    = 2'd1,
        BOP_FRAME = 2'd2
    } bop_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_BUS,
        ACT_VSYNC,
        ACT_IRQ
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_WCONT,
        ST_WVS
    } st_e;

    typedef struct packed {
        act_e              act;
        bop_e              op;
        logic              a0;
        logic [BYTE_W-1:0] data;
    } dec_t;

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        opc_e opc;
        opc    = opc_e'(w[OPC_LSB +: OPC_W]);
        d.act  = ACT_NONE;
        d.op   = BOP_WR;
        d.a0   = w[A0_POS];
        d.data = w[BYTE_W-1:0];
        case (opc)
            OPC_READ:  begin d.act = ACT_BUS; d.op = BOP_RD; end
            OPC_WRITE: begin d.act = ACT_BUS; d.op = BOP_WR; end
            OPC_FRAME: begin
                if (w[A0_POS]) begin
                    d.act = ACT_BUS;
                    d.op  = BOP_FRAME;
                end
            end
            OPC_VSYNC: d.act = ACT_VSYNC;
            OPC_IRQ:   d.act = ACT_IRQ;
            default:   d.act = ACT_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lcdcmd_decode.sv
module lcdcmd_decode
    import lcdcmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic unused_hi;
    assign unused_hi = ^word[WORD_W-1:OPC_LSB+OPC_W];
    assign dec = decode_word(word);
endmodule

// File: rtl/lcdcmd_ctrl.sv
module lcdcmd_ctrl
    import lcdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              stopped,
    input  logic              cont,
    input  logic              vsync,
    input  logic              cmd_valid,
    input  dec_t              dec,
    output logic              cmd_ready,
    output logic              bus_req,
    output logic [BOP_W-1:0]  bus_op,
    output logic              bus_a0,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_ack,
    output logic              cap_valid,
    output logic              cont_clr,
    output logic              irq_set
);
    st_e               st_q;
    bop_e              op_q;
    logic              a0_q;
    logic [BYTE_W-1:0] data_q;
    logic              take;
    logic              rd_done;

    assign cmd_ready = (st_q == ST_IDLE) && en && !stopped;
    assign take      = cmd_valid && cmd_ready;
    assign rd_done   = (st_q == ST_BUS) && bus_ack && (op_q == BOP_RD);
    assign cap_valid = rd_done;
    assign cont_clr  = cont && (rd_done || (st_q == ST_WCONT));
    assign irq_set   = take && (dec.act == ACT_IRQ);

    assign bus_req   = (st_q == ST_BUS);
    assign bus_op    = op_q;
    assign bus_a0    = a0_q;
    assign bus_wdata = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= BOP_RD;
            a0_q   <= 1'b0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        case (dec.act)
                            ACT_BUS: begin
                                st_q   <= ST_BUS;
                                op_q   <= dec.op;
                                a0_q   <= dec.a0;
                                data_q <= dec.data;
                            end
                            ACT_VSYNC: st_q <= ST_WVS;
                            default:   st_q <= ST_IDLE;
                        endcase
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        if (op_q == BOP_RD && !cont) st_q <= ST_WCONT;
                        else                         st_q <= ST_IDLE;
                    end
                end
                ST_WCONT: if (cont || stopped) st_q <= ST_IDLE;
                ST_WVS:   if (vsync || stopped) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // R5: request held with stable fields until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_a0) && $stable(bus_wdata)));

    // R5: request dropped after acknowledge
    a_r5_req_release: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> !bus_req);

    // R1: a taken bus word raises the request next cycle
    a_r1_take_to_req: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && dec.act == ACT_BUS) |=> bus_req);

    // R7: no progress past a read until continue or stop
    a_r7_cont_stall: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WCONT && !cont && !stopped) |=> (st_q == ST_WCONT));

    // R8: no progress past a vsync wait until vsync or stop
    a_r8_vsync_stall: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WVS && !vsync && !stopped) |=> (st_q == ST_WVS));

    // R11: stop ends any wait state
    a_r11_stop_exits: assert property (@(posedge clk) disable iff (rst)
        (stopped && (st_q == ST_WVS || st_q == ST_WCONT)) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/lcdcmd_regs.sv
module lcdcmd_regs
    import lcdcmd_pkg::*;
#(
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              cap_valid,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic              cap_a0,
    input  logic              cont_clr,
    input  logic              irq_set,
    output logic              stopped,
    output logic              cont,
    output logic              irq
);
    logic              stop_q;
    logic              ok_q;
    logic              cont_q;
    logic              a0src_q;
    logic [BYTE_W-1:0] byte_q;
    logic              irq_q;
    logic              wr_stop, wr_pst, wr_int;
    logic              unused_wd;

    assign unused_wd = ^{reg_wdata[WORD_W-1:PST_CONT+1], reg_wdata[PST_OK-1:1]};

    assign wr_stop = reg_wr && (reg_addr == REG_AW'(ADDR_STOP));
    assign wr_pst  = reg_wr && (reg_addr == REG_AW'(ADDR_PST));
    assign wr_int  = reg_wr && (reg_addr == REG_AW'(ADDR_INT));

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q  <= 1'b0;
            ok_q    <= 1'b0;
            cont_q  <= 1'b0;
            a0src_q <= 1'b0;
            byte_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_stop) stop_q <= reg_wdata[0];
            if (wr_pst) begin
                ok_q   <= reg_wdata[PST_OK];
                cont_q <= reg_wdata[PST_CONT];
            end
            if (cap_valid) begin
                byte_q  <= cap_byte;
                a0src_q <= cap_a0;
                ok_q    <= 1'b1;
            end
            if (cont_clr) cont_q <= 1'b0;
            if (wr_int && reg_wdata[0]) irq_q <= 1'b0;
            if (irq_set) irq_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(ADDR_STOP): reg_rdata[0] = stop_q;
            REG_AW'(ADDR_PST): begin
                reg_rdata[BYTE_W-1:0] = byte_q;
                reg_rdata[A0_POS]     = a0src_q;
                reg_rdata[PST_OK]     = ok_q;
                reg_rdata[PST_CONT]   = cont_q;
            end
            REG_AW'(ADDR_INT): reg_rdata[0] = irq_q;
            default: reg_rdata = '0;
        endcase
    end

    assign stopped = stop_q;
    assign cont    = cont_q;
    assign irq     = irq_q;

    // R10: interrupt bit holds until a write of 1 clears it
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !(wr_int && reg_wdata[0])) |=> irq_q);

    // R6: a read acknowledge captures the byte and sets status OK
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> (ok_q && byte_q == $past(cap_byte) && a0src_q == $past(cap_a0)));

    // R7: continue flag consumed when the sequencer moves on
    a_r7_cont_clear: assert property (@(posedge clk) disable iff (rst)
        (cont_clr && !wr_pst) |=> !cont_q);

endmodule

// File: rtl/lcdcmd_seq.sv
module lcdcmd_seq
    import lcdcmd_pkg::*;
#(
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              cmd_ready,
    input  logic              vsync,
    output logic              bus_req,
    output logic [BOP_W-1:0]  bus_op,
    output logic              bus_a0,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    dec_t dec;
    logic stopped, cont, cap_valid, cont_clr, irq_set;

    lcdcmd_decode u_dec (
        .word (cmd_word),
        .dec  (dec)
    );

    lcdcmd_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .stopped   (stopped),
        .cont      (cont),
        .vsync     (vsync),
        .cmd_valid (cmd_valid),
        .dec       (dec),
        .cmd_ready (cmd_ready),
        .bus_req   (bus_req),
        .bus_op    (bus_op),
        .bus_a0    (bus_a0),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .cap_valid (cap_valid),
        .cont_clr  (cont_clr),
        .irq_set   (irq_set)
    );

    lcdcmd_regs #(.REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_valid (cap_valid),
        .cap_byte  (bus_rdata),
        .cap_a0    (bus_a0),
        .cont_clr  (cont_clr),
        .irq_set   (irq_set),
        .stopped   (stopped),
        .cont      (cont),
        .irq       (irq)
    );

endmodule

// File: tb/lcdcmd_seq_bench.sv
`timescale 1ns/1ps
module lcdcmd_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        vsync = 1'b0;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        cmd_ready, bus_req, bus_a0, irq;
    logic [1:0]  bus_op;
    logic [7:0]  bus_wdata;
    logic [15:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    bit exp_irq = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcdcmd_seq u_lcdcmd_seq (
        .clk(clk), .rst(rst), .en(en), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .vsync(vsync), .bus_req(bus_req), .bus_op(bus_op),
        .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // kind: 0 none, 1 bus, 2 vsync wait, 3 interrupt
    function automatic int exp_kind(input logic [15:0] w);
        case (w[11:9])
            3'd0, 3'd1: return 1;
            3'd2:       return w[8] ? 1 : 0;
            3'd3:       return 2;
            3'd5:       return 3;
            default:    return 0;
        endcase
    endfunction

    function automatic int exp_bop(input logic [15:0] w);
        return (w[11:9] == 3'd0) ? 0 : (w[11:9] == 3'd1) ? 1 : 2;
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        case (w[11:9])
            3'd0:    return "R2";
            3'd1:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_word(input logic [15:0] w, input logic [7:0] rd, input bit pre_cont);
        int kind;
        int n;
        logic [15:0] v;
        logic [15:0] ev;
        kind = exp_kind(w);
        if (pre_cont) reg_write(2'd1, 16'h0400);
        chk(cmd_ready === 1'b1, "R1 ready before word", cmd_ready, 1);
        cmd_word = w; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        case (kind)
            1: begin
                chk(bus_req === 1'b1, tag_of(w), bus_req, 1);
                chk(bus_op == 2'(exp_bop(w)), tag_of(w), bus_op, exp_bop(w));
                chk({bus_a0, bus_wdata} == w[8:0], tag_of(w), {bus_a0, bus_wdata}, w[8:0]);
                n = int'($urandom % 3);
                repeat (n) begin
                    @(negedge clk);
                    chk(bus_req && {bus_a0, bus_wdata} == w[8:0] && bus_op == 2'(exp_bop(w)),
                        "R5 hold", {bus_req, bus_a0, bus_wdata}, {1'b1, w[8:0]});
                end
                bus_rdata = rd; bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
                chk(!bus_req, "R5 release", bus_req, 0);
                if (w[11:9] == 3'd0) begin
                    reg_read(2'd1, v);
                    ev = {5'd0, 1'b0, 1'b1, w[8], rd};
                    chk(v == ev, "R6 capture", v, ev);
                    if (pre_cont) begin
                        chk(cmd_ready, "R7 preset continue", cmd_ready, 1);
                    end else begin
                        chk(!cmd_ready, "R7 stall", cmd_ready, 0);
                        @(negedge clk);
                        chk(!cmd_ready, "R7 stall", cmd_ready, 0);
                        reg_write(2'd1, 16'h0600);
                        chk(!cmd_ready, "R7 one cycle", cmd_ready, 0);
                        @(negedge clk);
                        chk(cmd_ready, "R7 resume", cmd_ready, 1);
                        reg_read(2'd1, v);
                        chk(v[10] == 1'b0, "R7 flag cleared", v[10], 0);
                    end
                end else begin
                    chk(cmd_ready, tag_of(w), cmd_ready, 1);
                end
            end
            2: begin
                chk(!cmd_ready, "R8 stall", cmd_ready, 0);
                @(negedge clk);
                chk(!cmd_ready, "R8 stall", cmd_ready, 0);
                vsync = 1'b1;
                @(negedge clk);
                vsync = 1'b0;
                chk(cmd_ready, "R8 resume", cmd_ready, 1);
            end
            3: begin
                exp_irq = 1'b1;
                chk(irq, "R10 set", irq, 1);
                chk(cmd_ready && !bus_req, "R10 no bus", {cmd_ready, bus_req}, 2);
            end
            default: begin
                chk(cmd_ready && !bus_req, (w[11:9] == 3'd2) ? "R4 frame A0=0" : "R9 no-op",
                    {cmd_ready, bus_req}, 2);
            end
        endcase
        chk(irq == exp_irq, "R10 level", irq, exp_irq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [15:0] v;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20080407);
        en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk(cmd_ready && !bus_req && !irq, "R12 outputs", {cmd_ready, bus_req, irq}, 4);
        reg_read(2'd0, v); chk(v == 0, "R12 stop reg", v, 0);
        reg_read(2'd1, v); chk(v == 0, "R12 status reg", v, 0);
        reg_read(2'd2, v); chk(v == 0, "R12 int reg", v, 0);
        @(negedge clk);

        // R1 enable gates fetch
        en = 1'b0;
        #1 chk(!cmd_ready, "R1 enable low", cmd_ready, 0);
        cmd_word = 16'h0233; cmd_valid = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(!bus_req, "R1 no fetch when disabled", bus_req, 0);
        end
        cmd_valid = 1'b0; en = 1'b1;
        @(negedge clk);

        // directed opcodes
        do_word(16'h0012, 8'h81, 1'b0);   // read status
        do_word(16'h0134, 8'h7e, 1'b0);   // read frame memory
        do_word(16'h0256, 8'h00, 1'b0);   // write command
        do_word(16'hF378, 8'h00, 1'b0);   // write data, top bits ignored
        do_word(16'h0599, 8'h00, 1'b0);   // frame write
        do_word(16'h0499, 8'h00, 1'b0);   // op2 A0=0 no-op
        do_word(16'h0800, 8'h00, 1'b0);   // nop
        do_word(16'h0C00, 8'h00, 1'b0);   // op6
        do_word(16'h0E00, 8'h00, 1'b0);   // op7
        do_word(16'h0101, 8'hc3, 1'b1);   // read with continue preset
        do_word(16'h0A00, 8'h00, 1'b0);   // interrupt
        reg_write(2'd2, 16'h0000);
        chk(irq, "R10 write 0 keeps", irq, 1);
        do_word(16'h0800, 8'h00, 1'b0);   // interrupt survives other words
        reg_write(2'd2, 16'h0001);
        exp_irq = 1'b0;
        chk(!irq, "R10 clear", irq, 0);
        do_word(16'h0600, 8'h00, 1'b0);   // vsync wait

        // R11 stop while waiting for vsync
        cmd_word = 16'h0600; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        reg_write(2'd0, 16'h0001);
        @(negedge clk);
        reg_read(2'd0, v); chk(v == 16'h0001, "R11 stop flag", v, 1);
        cmd_word = 16'h0201; cmd_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!bus_req && !cmd_ready, "R11 blocked", {bus_req, cmd_ready}, 0);
        end
        cmd_valid = 1'b0;
        reg_write(2'd0, 16'h0000);
        chk(cmd_ready, "R11 released from vsync wait", cmd_ready, 1);

        // R11 stop while waiting for continue
        cmd_word = 16'h0011; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bus_rdata = 8'h5a; bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(!cmd_ready, "R7 waiting", cmd_ready, 0);
        reg_write(2'd0, 16'h0001);
        @(negedge clk);
        reg_write(2'd0, 16'h0000);
        chk(cmd_ready, "R11 released from continue wait", cmd_ready, 1);
        reg_read(2'd1, v); chk(v == 16'h025a, "R11 status kept", v, 16'h025a);
        @(negedge clk);

        // constrained random stream
        for (int i = 0; i < 250; i++) begin
            logic [15:0] w;
            bit pre;
            w = {4'($urandom), 3'($urandom % 8), 1'($urandom), 8'($urandom)};
            pre = (w[11:9] == 3'd0) && ($urandom % 4 == 0);
            do_word(w, 8'($urandom), pre);
            if (exp_irq && ($urandom % 2 == 0)) begin
                reg_write(2'd2, 16'h0001);
                exp_irq = 1'b0;
                chk(!irq, "R10 random clear", irq, 0);
            end
        end

        done = 1'b1;
        summary();
    end

endmodule